// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block caches translations from virtual page numbers to physical page numbers for a small number of pages. Every entry carries a process identifier next to its virtual page tag. Entries from several address spaces can therefore stay resident across a context switch, and a lookup only succeeds for the process that installed the entry. All entries are compared at once. The result of a lookup is registered and appears one cycle after the request. The result is one of three outcomes: a translated physical address, a miss that asks an external walker for a refill, or a protection fault.

Pages are 8 KB. The low 13 address bits pass through translation unchanged, and the page number is replaced by the stored physical page number. Each entry also holds four permission bits and a dirty bit. A permitted write to a clean page reports that the page-table dirty bit needs an update, and it marks the entry dirty. The walker installs complete entries through a refill port. A flush port either empties the whole buffer or removes one process's entries. The entry count is a parameter; typical sizes are 8 for instruction fetch and 32 for data.

There is no sequencing state machine. Storage and the round-robin pointer change only at the clock edge, and the fixed update priority is flush, then refill, then dirty marking.

Top module: `ptag_tlb`

## Requirements
- R1: After reset every entry is invalid, all result outputs are low, and the first lookup reports a miss.
- R2: A lookup hits only when a valid entry matches both the virtual page number and the process ID. The same page under a different process ID misses.
- R3: A lookup presented in cycle N produces a result in cycle N+1 with `rs_valid` high and exactly one of `rs_hit`, `rs_miss` and `rs_fault` high. With no lookup, `rs_valid` is low.
- R4: On a hit, `rs_paddr` is the stored physical page number followed by the unchanged 13-bit page offset. Otherwise `rs_paddr` is zero.
- R5: The permission encoding is bit 0 read, bit 1 write, bit 2 execute and bit 3 user-accessible. The access kind is 0 read, 1 write, 2 execute, and 3 is treated as read. A matching entry whose bit for the kind is clear, or a user-mode access to an entry whose bit 3 is clear, raises `rs_fault` with `rs_hit` low and a zero address.
- R6: A permitted write that hits an entry whose dirty bit is clear raises `rs_dirty_upd` and sets the stored dirty bit, so the next write to that page does not raise it. Reads never raise it.
- R7: A refill writes into a valid entry that already holds the same page and process, if there is one. Otherwise it writes into the lowest-numbered invalid entry. If every entry is valid, it writes into the entry at a round-robin pointer that starts at 0 and advances only on such an eviction.
- R8: A flush with `fl_by_pid` low invalidates every entry in one cycle.
- R9: A flush with `fl_by_pid` high invalidates only the entries whose process ID equals `fl_pid`.
- R10: A flush wins over a refill in the same cycle, and that refill is dropped. A lookup in the same cycle as a refill or a flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_pid | input | PID_W | Process ID of the request |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| lk_user | input | 1 | Request comes from user mode |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VA_W-13 | Virtual page number to install |
| rf_pid | input | PID_W | Process ID to install |
| rf_ppn | input | PA_W-13 | Physical page number to install |
| rf_perm | input | 4 | Permission bits to install |
| rf_dirty | input | 1 | Dirty bit to install |
| fl_valid | input | 1 | Flush request |
| fl_by_pid | input | 1 | Flush only entries of `fl_pid` |
| fl_pid | input | PID_W | Process ID for a selective flush |
| rs_valid | output | 1 | Result valid, one cycle after the lookup |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No matching entry; a refill is needed |
| rs_fault | output | 1 | Matching entry, but access not permitted |
| rs_dirty_upd | output | 1 | Page-table dirty bit needs setting |
| rs_paddr | output | PA_W | Translated physical address |

## Verification
The hardest situation to reach is a full buffer: the round-robin pointer only shows its effect after every entry is valid. It must also be shown that an overwrite of an existing page neither duplicates that page nor advances the pointer. The bench uses a four-entry instance. It first fills the buffer, then forces two evictions and confirms which pages are gone. It then re-installs a resident page and shows that the next new page evicts the entry the pointer already held, not its neighbour. Same-edge collisions are also driven: flush with refill, and refill with lookup.

// File: rtl/ptlb_pkg.sv
`timescale 1ns/1ps
package ptlb_pkg;

    localparam int OFF_W = 13;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RD2   = 2'd3
    } acc_kind_e;

    localparam int PB_READ  = 0;
    localparam int PB_WRITE = 1;
    localparam int PB_EXEC  = 2;
    localparam int PB_USER  = 3;

    function automatic logic perm_ok(input logic [3:0] perm,
                                     input logic [1:0] kind,
                                     input logic user);
        logic need;
        unique case (acc_kind_e'(kind))
            ACC_WRITE: need = perm[PB_WRITE];
            ACC_EXEC:  need = perm[PB_EXEC];
            default:   need = perm[PB_READ];
        endcase
        return need && (!user || perm[PB_USER]);
    endfunction

endpackage

// File: rtl/ptlb_cam.sv
`timescale 1ns/1ps
module ptlb_cam #(
    parameter int N  = 32,
    parameter int KW = 38
) (
    input  logic [N-1:0]         valid_vec,
    input  logic [N-1:0][KW-1:0] tags,
    input  logic [KW-1:0]        key,
    output logic [N-1:0]         hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tags[g] == key);
    end
endmodule

// File: rtl/ptlb_victim.sv
`timescale 1ns/1ps
module ptlb_victim #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] valid_vec,
    input  logic [N-1:0] same_vec,
    input  logic         commit,
    output logic [N-1:0] victim_oh
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] rr_q;
    logic [N-1:0]     inv, first_inv, first_same, rr_oh;
    logic             use_rr;

    always_comb begin
        inv        = ~valid_vec;
        first_inv  = inv & (~inv + 1'b1);
        first_same = same_vec & (~same_vec + 1'b1);
        rr_oh      = {{(N-1){1'b0}}, 1'b1} << rr_q;
        use_rr     = (same_vec == '0) && (&valid_vec);
        if (same_vec != '0)      victim_oh = first_same;
        else if (inv != '0)      victim_oh = first_inv;
        else                     victim_oh = rr_oh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (commit && use_rr)
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    AST_RR_HOLD_ON_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (same_vec != '0)) |=> $stable(rr_q)); // R7
    AST_VICTIM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(same_vec)); // R7
endmodule

// File: rtl/ptag_tlb.sv
`timescale 1ns/1ps
module ptag_tlb #(
    parameter int ENTRIES = 32,
    parameter int VA_W    = 43,
    parameter int PA_W    = 34,
    parameter int PID_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic [PID_W-1:0]      lk_pid,
    input  logic [1:0]            lk_kind,
    input  logic                  lk_user,
    input  logic                  rf_valid,
    input  logic [VA_W-14:0]      rf_vpn,
    input  logic [PID_W-1:0]      rf_pid,
    input  logic [PA_W-14:0]      rf_ppn,
    input  logic [3:0]            rf_perm,
    input  logic                  rf_dirty,
    input  logic                  fl_valid,
    input  logic                  fl_by_pid,
    input  logic [PID_W-1:0]      fl_pid,
    output logic                  rs_valid,
    output logic                  rs_hit,
    output logic                  rs_miss,
    output logic                  rs_fault,
    output logic                  rs_dirty_upd,
    output logic [PA_W-1:0]       rs_paddr
);
    import ptlb_pkg::*;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int KW    = PID_W + VPN_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]              v_q, d_q;
    logic [ENTRIES-1:0][KW-1:0]      tag_q;
    logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q;
    logic [ENTRIES-1:0][3:0]         perm_q;

    logic [ENTRIES-1:0] lk_hits, rf_same, victim_oh, flush_clr, dset;
    logic [IDX_W-1:0]   hit_idx;
    logic               any_hit, access_ok, want_dirty, rf_commit;
    logic [PPN_W-1:0]   sel_ppn;

    ptlb_cam #(.N(ENTRIES), .KW(KW)) u_cam_lk (
        .valid_vec(v_q), .tags(tag_q),
        .key({lk_pid, lk_vaddr[VA_W-1:OFF_W]}), .hit_vec(lk_hits));

    ptlb_cam #(.N(ENTRIES), .KW(KW)) u_cam_rf (
        .valid_vec(v_q), .tags(tag_q),
        .key({rf_pid, rf_vpn}), .hit_vec(rf_same));

    assign rf_commit = rf_valid && !fl_valid;

    ptlb_victim #(.N(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid_vec(v_q), .same_vec(rf_same),
        .commit(rf_commit), .victim_oh(victim_oh));

    // Lookup datapath: encode the single match and check the rights
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (lk_hits[i]) hit_idx = hit_idx | IDX_W'(i);
        any_hit    = |lk_hits;
        sel_ppn    = ppn_q[hit_idx];
        access_ok  = perm_ok(perm_q[hit_idx], lk_kind, lk_user);
        want_dirty = lk_valid && any_hit && access_ok &&
                     (acc_kind_e'(lk_kind) == ACC_WRITE) && !d_q[hit_idx];
        dset       = want_dirty ? lk_hits : '0;
        for (int i = 0; i < ENTRIES; i++)
            flush_clr[i] = fl_valid &&
                (!fl_by_pid || (tag_q[i][KW-1 -: PID_W] == fl_pid));
    end

    // Entry storage: flush, then refill, then dirty marking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= '0;
            d_q    <= '0;
            tag_q  <= '0;
            ppn_q  <= '0;
            perm_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_clr[i]) begin
                    v_q[i] <= 1'b0;
                end else if (rf_commit && victim_oh[i]) begin
                    v_q[i]    <= 1'b1;
                    d_q[i]    <= rf_dirty;
                    tag_q[i]  <= {rf_pid, rf_vpn};
                    ppn_q[i]  <= rf_ppn;
                    perm_q[i] <= rf_perm;
                end else if (dset[i]) begin
                    d_q[i] <= 1'b1;
                end
            end
        end
    end

    // Registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid     <= 1'b0;
            rs_hit       <= 1'b0;
            rs_miss      <= 1'b0;
            rs_fault     <= 1'b0;
            rs_dirty_upd <= 1'b0;
            rs_paddr     <= '0;
        end else begin
            rs_valid     <= lk_valid;
            rs_hit       <= lk_valid && any_hit && access_ok;
            rs_miss      <= lk_valid && !any_hit;
            rs_fault     <= lk_valid && any_hit && !access_ok;
            rs_dirty_upd <= want_dirty;
            rs_paddr     <= (lk_valid && any_hit && access_ok) ?
                            {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;
        end
    end

    AST_NO_DOUBLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hits)); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> ($countones({rs_hit, rs_miss, rs_fault}) == 1)); // R3
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid); // R3
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> (rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))); // R4
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rs_fault |-> (rs_paddr == '0)); // R5
    AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rs_dirty_upd |-> (rs_hit && ($past(lk_kind) == 2'd1))); // R6
    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !fl_by_pid) |=> (v_q == '0)); // R8
endmodule

// File: tb/ptag_tlb_tb.sv
`timescale 1ns/1ps
module ptag_tlb_tb_top;
    localparam int N     = 4;
    localparam int VA_W  = 43;
    localparam int PA_W  = 34;
    localparam int PID_W = 8;
    localparam int VPN_W = VA_W - 13;
    localparam int PPN_W = PA_W - 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, lk_user = 0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic [PID_W-1:0] lk_pid = '0;
    logic [1:0] lk_kind = '0;
    logic rf_valid = 0, rf_dirty = 0;
    logic [VPN_W-1:0] rf_vpn = '0;
    logic [PID_W-1:0] rf_pid = '0;
    logic [PPN_W-1:0] rf_ppn = '0;
    logic [3:0] rf_perm = '0;
    logic fl_valid = 0, fl_by_pid = 0;
    logic [PID_W-1:0] fl_pid = '0;
    logic rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty_upd;
    logic [PA_W-1:0] rs_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ptag_tlb #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .PID_W(PID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_pid(lk_pid), .lk_kind(lk_kind), .lk_user(lk_user),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pid(rf_pid), .rf_ppn(rf_ppn),
        .rf_perm(rf_perm), .rf_dirty(rf_dirty), .fl_valid(fl_valid),
        .fl_by_pid(fl_by_pid), .fl_pid(fl_pid), .rs_valid(rs_valid),
        .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
        .rs_dirty_upd(rs_dirty_upd), .rs_paddr(rs_paddr));

    function automatic logic [PA_W-1:0] pa(input int ppn, input int off);
        return {PPN_W'(ppn), 13'(off)};
    endfunction

    task automatic check_res(input string tag, input bit eh, input bit em,
                             input bit ef, input bit ed, input logic [PA_W-1:0] ep);
        n_chk++;
        if ({rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty_upd, rs_paddr} !==
            {1'b1, eh, em, ef, ed, ep}) begin
            n_bad++;
            $display("FAIL %s: got v%b h%b m%b f%b d%b pa=%h expected v1 h%b m%b f%b d%b pa=%h",
                     tag, rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty_upd, rs_paddr,
                     eh, em, ef, ed, ep);
        end
    endtask

    task automatic drive_lk(input int vpn, input int off, input int pid,
                            input int kind, input bit user);
        lk_valid = 1; lk_vaddr = {VPN_W'(vpn), 13'(off)};
        lk_pid = PID_W'(pid); lk_kind = 2'(kind); lk_user = user;
    endtask

    task automatic lookup(input int vpn, input int off, input int pid,
                          input int kind, input bit user);
        @(negedge clk);
        drive_lk(vpn, off, pid, kind, user);
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic drive_rf(input int vpn, input int pid, input int ppn,
                            input logic [3:0] perm, input bit dirty);
        rf_valid = 1; rf_vpn = VPN_W'(vpn); rf_pid = PID_W'(pid);
        rf_ppn = PPN_W'(ppn); rf_perm = perm; rf_dirty = dirty;
    endtask

    task automatic refill(input int vpn, input int pid, input int ppn,
                          input logic [3:0] perm, input bit dirty);
        @(negedge clk);
        drive_rf(vpn, pid, ppn, perm, dirty);
        @(negedge clk);
        rf_valid = 0;
    endtask

    task automatic flush(input bit by_pid, input int pid);
        @(negedge clk);
        fl_valid = 1; fl_by_pid = by_pid; fl_pid = PID_W'(pid);
        @(negedge clk);
        fl_valid = 0;
    endtask

    task automatic t_reset();
        n_chk++;
        if ({rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty_upd, rs_paddr} !== '0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: got %b expected 0",
                     {rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty_upd});
        end
        lookup(5, 0, 1, 0, 0);
        check_res("R1 first lookup misses", 0, 1, 0, 0, '0);
    endtask

    task automatic t_basic();
        refill('h10, 1, 'h123, 4'b1111, 1);
        lookup('h10, 'h1abc, 1, 0, 1);
        check_res("R2 R4 hit builds address", 1, 0, 0, 0, pa('h123, 'h1abc));
        lookup('h10, 'h0005, 2, 0, 1);
        check_res("R2 other pid misses", 0, 1, 0, 0, '0);
        lookup('h11, 'h0005, 1, 0, 1);
        check_res("R2 other vpn misses", 0, 1, 0, 0, '0);
        @(negedge clk);
        n_chk++;
        if (rs_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R3 idle result: got %b expected 0", rs_valid);
        end
    endtask

    task automatic t_perm();
        refill('h20, 1, 'h55, 4'b0001, 1);
        lookup('h20, 'h10, 1, 0, 0);
        check_res("R5 read allowed", 1, 0, 0, 0, pa('h55, 'h10));
        lookup('h20, 'h10, 1, 3, 0);
        check_res("R5 kind 3 as read", 1, 0, 0, 0, pa('h55, 'h10));
        lookup('h20, 'h10, 1, 1, 0);
        check_res("R5 write denied", 0, 0, 1, 0, '0);
        lookup('h20, 'h10, 1, 2, 0);
        check_res("R5 exec denied", 0, 0, 1, 0, '0);
        lookup('h20, 'h10, 1, 0, 1);
        check_res("R5 user denied", 0, 0, 1, 0, '0);
    endtask

    task automatic t_dirty();
        refill('h30, 1, 'h77, 4'b1011, 0);
        lookup('h30, 'h22, 1, 0, 1);
        check_res("R6 read no dirty update", 1, 0, 0, 0, pa('h77, 'h22));
        lookup('h30, 'h22, 1, 1, 1);
        check_res("R6 first write flags dirty", 1, 0, 0, 1, pa('h77, 'h22));
        lookup('h30, 'h23, 1, 1, 1);
        check_res("R6 second write clean", 1, 0, 0, 0, pa('h77, 'h23));
        lookup('h10, 'h23, 1, 1, 1);
        check_res("R6 write to installed dirty page", 1, 0, 0, 0, pa('h123, 'h23));
    endtask

    task automatic t_flush_pid();
        refill('h10, 2, 'h99, 4'b1111, 1);
        flush(1, 1);
        lookup('h10, 0, 1, 0, 0);
        check_res("R9 pid 1 removed", 0, 1, 0, 0, '0);
        lookup('h30, 0, 1, 0, 0);
        check_res("R9 pid 1 other page removed", 0, 1, 0, 0, '0);
        lookup('h10, 8, 2, 0, 0);
        check_res("R9 pid 2 kept", 1, 0, 0, 0, pa('h99, 8));
    endtask

    task automatic t_flush_all();
        flush(0, 0);
        lookup('h10, 8, 2, 0, 0);
        check_res("R8 all removed", 0, 1, 0, 0, '0);
        @(negedge clk);
        fl_valid = 1; fl_by_pid = 0;
        drive_rf('h50, 1, 'h50, 4'b1111, 1);
        @(negedge clk);
        fl_valid = 0; rf_valid = 0;
        lookup('h50, 0, 1, 0, 0);
        check_res("R10 flush drops refill", 0, 1, 0, 0, '0);
        @(negedge clk);
        drive_rf('h40, 1, 'h140, 4'b1111, 1);
        drive_lk('h40, 0, 1, 0, 0);
        @(negedge clk);
        rf_valid = 0; lk_valid = 0;
        check_res("R10 lookup sees old contents", 0, 1, 0, 0, '0);
        lookup('h40, 0, 1, 0, 0);
        check_res("R10 refill then visible", 1, 0, 0, 0, pa('h140, 0));
    endtask

    task automatic t_replace();
        for (int k = 'h41; k <= 'h45; k++) refill(k, 1, k + 'h100, 4'b1111, 1);
        lookup('h40, 0, 1, 0, 0);
        check_res("R7 rr evicts entry 0", 0, 1, 0, 0, '0);
        lookup('h41, 0, 1, 0, 0);
        check_res("R7 rr evicts entry 1", 0, 1, 0, 0, '0);
        lookup('h42, 0, 1, 0, 0);
        check_res("R7 entry 2 kept", 1, 0, 0, 0, pa('h142, 0));
        lookup('h45, 0, 1, 0, 0);
        check_res("R7 newest present", 1, 0, 0, 0, pa('h145, 0));
        refill('h43, 1, 'h3aa, 4'b1111, 1);
        lookup('h43, 4, 1, 0, 0);
        check_res("R7 overwrite in place", 1, 0, 0, 0, pa('h3aa, 4));
        lookup('h42, 0, 1, 0, 0);
        check_res("R7 overwrite evicts nothing", 1, 0, 0, 0, pa('h142, 0));
        refill('h46, 1, 'h146, 4'b1111, 1);
        lookup('h42, 0, 1, 0, 0);
        check_res("R7 pointer not advanced by overwrite", 0, 1, 0, 0, '0);
        lookup('h43, 0, 1, 0, 0);
        check_res("R7 neighbour kept", 1, 0, 0, 0, pa('h3aa, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_perm();
        t_dirty();
        t_flush_pid();
        t_flush_all();
        t_replace();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule